// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit processor pipeline and a word-addressed memory bus whose byte lanes are numbered big-endian, so byte offset 0 is carried on data bits 31..24. The core presents one memory instruction word, together with two register values: the value selected by instruction bits 25..21, which is the address base, and the value selected by bits 20..16, which is the store source. The block decodes the 6-bit opcode in bits 31..26. It adds the sign-extended 16-bit immediate to the base to form the effective address. It then issues a single bus request that carries a word address, byte enables and, for a store, the lane-replicated write data.

For a load, the bus returns a full word. The block picks the addressed byte or halfword out of that word and extends it to 32 bits, with sign or zero extension chosen by the opcode. Signed and unsigned loads share one extraction path. The result is handed back as a one-cycle pulse that carries the destination register index. Only one access can be outstanding at a time. A halfword or word access whose address is not naturally aligned raises a one-cycle error flag and never reaches the bus.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `base_val` plus bits 15..0 of the instruction, sign-extended to 32 bits. `bus_waddr` carries effective-address bits 31..2, and bits 1..0 form the byte offset.
- R2: Only opcodes 4, 16, 7, 11 and 10 (loads) and 12, 3 and 22 (stores) in bits 31..26 start an access. A request carrying any other opcode is ignored: no bus request and no error flag.
- R3: The byte enables, written with bit 3 for offset 0, are 1000, 0100, 0010 and 0001 for a byte at offsets 0 to 3. A halfword gets 1100 at offset 0 and 0011 at offset 2. A word gets 1111.
- R4: A store drives `bus_we` high. A byte store replicates `src_val[7:0]` on all four lanes. A halfword store replicates `src_val[15:0]` on both halves. A word store sends `src_val` unchanged.
- R5: A halfword access with address bit 0 set, or a word access with address bits 1..0 nonzero, pulses `mis_flag` for one cycle in the cycle after the request and raises no bus request.
- R6: A load takes the addressed byte or halfword from big-endian lanes. Opcodes 4 (byte) and 7 (halfword) sign-extend it, opcodes 16 (byte) and 11 (halfword) zero-extend it, and opcode 10 returns the whole word.
- R7: `ld_valid` is high for exactly one cycle, the cycle after the bus acknowledges a load. In that cycle `ld_data` holds the result and `ld_idx` holds instruction bits 20..16.
- R8: `bus_req` rises in the cycle after an accepted request and stays high, with its address, enables and data held, until `bus_ack` is sampled. `req_valid` is ignored while `busy` is high.
- R9: After reset, `busy`, `bus_req`, `ld_valid` and `mis_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Memory instruction word |
| base_sel | output | 5 | Register index of the address base (instr bits 25..21) |
| src_sel | output | 5 | Register index of the store source or load destination (instr bits 20..16) |
| base_val | input | 32 | Value of the base register |
| src_val | input | 32 | Value of the store source register |
| busy | output | 1 | An access is outstanding |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write strobe |
| bus_waddr | output | 30 | Word address |
| bus_be | output | 4 | Byte enables, bit 3 is byte offset 0 |
| bus_wdata | output | 32 | Write data, lane-replicated |
| bus_ack | input | 1 | Bus completes the current request |
| bus_rdata | input | 32 | Read word, valid with `bus_ack` |
| ld_valid | output | 1 | Load result pulse |
| ld_idx | output | 5 | Destination register index of the load |
| ld_data | output | 32 | Extended load result |
| mis_flag | output | 1 | Misaligned-access error pulse |

## Verification
The checker assumes that the bus raises `bus_ack` only while `bus_req` is high. It also assumes that `bus_rdata` is meaningful only in the cycle `bus_ack` is high. The bench's bus model follows both rules: it acknowledges only after it has observed the request, and it drives read data in the same cycle as the acknowledge. Stimulus presents a new instruction while an access is outstanding only in the scenario that checks it is ignored. Acknowledges are delayed by zero to several cycles so that the hold rule is observed with a live request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned OPC_W = 6;

    // access width
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } lsu_size_e;

    // opcode values (instruction bits 31..26)
    localparam logic [OPC_W-1:0] OPC_LD_S8  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_LD_U8  = 6'd16;
    localparam logic [OPC_W-1:0] OPC_LD_S16 = 6'd7;
    localparam logic [OPC_W-1:0] OPC_LD_U16 = 6'd11;
    localparam logic [OPC_W-1:0] OPC_LD_32  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ST_8   = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ST_16  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_ST_32  = 6'd22;

    typedef struct packed {
        logic      is_mem;
        logic      is_load;
        logic      sgn;
        lsu_size_e size;
    } lsu_dec_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output lsu_dec_t         dec
);
    always_comb begin
        dec = '{is_mem: 1'b0, is_load: 1'b0, sgn: 1'b0, size: SZ_WORD};
        unique case (opc)
            OPC_LD_S8:  dec = '{is_mem: 1'b1, is_load: 1'b1, sgn: 1'b1, size: SZ_BYTE};
            OPC_LD_U8:  dec = '{is_mem: 1'b1, is_load: 1'b1, sgn: 1'b0, size: SZ_BYTE};
            OPC_LD_S16: dec = '{is_mem: 1'b1, is_load: 1'b1, sgn: 1'b1, size: SZ_HALF};
            OPC_LD_U16: dec = '{is_mem: 1'b1, is_load: 1'b1, sgn: 1'b0, size: SZ_HALF};
            OPC_LD_32:  dec = '{is_mem: 1'b1, is_load: 1'b1, sgn: 1'b0, size: SZ_WORD};
            OPC_ST_8:   dec = '{is_mem: 1'b1, is_load: 1'b0, sgn: 1'b0, size: SZ_BYTE};
            OPC_ST_16:  dec = '{is_mem: 1'b1, is_load: 1'b0, sgn: 1'b0, size: SZ_HALF};
            OPC_ST_32:  dec = '{is_mem: 1'b1, is_load: 1'b0, sgn: 1'b0, size: SZ_WORD};
            default:    ;
        endcase
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  lsu_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    int          nb;
    logic [LANES:0] ones;

    always_comb begin
        unique case (size)
            SZ_BYTE: nb = 1;
            SZ_HALF: nb = 2;
            default: nb = LANES;
        endcase
        ones = ((LANES+1)'(1) << nb) - (LANES+1)'(1);
        // lowest enable belongs to the highest offset (big-endian)
        be   = ones[LANES-1:0] << (LANES - nb - int'(off));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // lane i carries byte offset i at bits DATA_W-1-8i downto DATA_W-8-8i
        localparam int unsigned HI = DATA_W - 1 - 8 * i;
        localparam int unsigned HB = (i % 2 == 0) ? 15 : 7;
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[HI -: 8] = src[7:0];
                SZ_HALF: wdata[HI -: 8] = src[HB -: 8];
                default: wdata[HI -: 8] = src[HI -: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  lsu_size_e         size,
    input  logic              sgn,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    int                nb;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        unique case (size)
            SZ_BYTE: nb = 1;
            SZ_HALF: nb = 2;
            default: nb = LANES;
        endcase
        // bring the addressed lanes down to bit 0; shared by signed and unsigned
        shifted = rdata >> (8 * (LANES - nb - int'(off)));
        unique case (size)
            SZ_BYTE: data = {{(DATA_W-8){sgn & shifted[7]}},   shifted[7:0]};
            SZ_HALF: data = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5,
    localparam int unsigned LANES  = DATA_W / 8,
    localparam int unsigned OFF_W  = $clog2(LANES),
    localparam int unsigned WA_W   = DATA_W - OFF_W,
    localparam int unsigned IMM_W  = 16,
    localparam int unsigned INSN_W = OPC_W + 2 * IDX_W + IMM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [INSN_W-1:0] instr,
    output logic [IDX_W-1:0]  base_sel,
    output logic [IDX_W-1:0]  src_sel,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] src_val,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WA_W-1:0]   bus_waddr,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              ld_valid,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data,
    output logic              mis_flag
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [WA_W-1:0]   waddr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        lsu_size_e         size;
        logic              sgn;
        logic [OFF_W-1:0]  off;
        logic [IDX_W-1:0]  idx;
        logic              ld_vld;
        logic [DATA_W-1:0] ld_data;
        logic              mis;
    } st_t;

    st_t st_d, st_q;

    // instruction fields
    logic [OPC_W-1:0]  opc;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] ea;
    logic [OFF_W-1:0]  ea_off;
    logic              misal;
    lsu_dec_t          dec;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] st_wdata;
    logic [DATA_W-1:0] ld_ext;

    assign opc      = instr[INSN_W-1 -: OPC_W];
    assign base_sel = instr[IMM_W + IDX_W +: IDX_W];
    assign src_sel  = instr[IMM_W +: IDX_W];
    assign imm      = instr[IMM_W-1:0];
    assign ea       = base_val + {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign ea_off   = ea[OFF_W-1:0];

    lsu_decode u_dec (
        .opc (opc),
        .dec (dec)
    );

    lsu_store_lane #(.DATA_W(DATA_W)) u_st (
        .size  (dec.size),
        .off   (ea_off),
        .src   (src_val),
        .be    (st_be),
        .wdata (st_wdata)
    );

    lsu_load_lane #(.DATA_W(DATA_W)) u_ld (
        .size  (st_q.size),
        .sgn   (st_q.sgn),
        .off   (st_q.off),
        .rdata (bus_rdata),
        .data  (ld_ext)
    );

    always_comb begin
        unique case (dec.size)
            SZ_BYTE: misal = 1'b0;
            SZ_HALF: misal = ea_off[0];
            default: misal = (ea_off != '0);
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.ld_vld = 1'b0;
        st_d.mis    = 1'b0;
        if (!st_q.busy) begin
            if (req_valid && dec.is_mem) begin
                if (misal) begin
                    st_d.mis = 1'b1;
                end else begin
                    st_d.busy  = 1'b1;
                    st_d.we    = !dec.is_load;
                    st_d.waddr = ea[DATA_W-1:OFF_W];
                    st_d.be    = st_be;
                    st_d.wdata = st_wdata;
                    st_d.size  = dec.size;
                    st_d.sgn   = dec.sgn;
                    st_d.off   = ea_off;
                    st_d.idx   = src_sel;
                end
            end
        end else if (bus_ack) begin
            st_d.busy = 1'b0;
            if (!st_q.we) begin
                st_d.ld_vld  = 1'b1;
                st_d.ld_data = ld_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{size: SZ_WORD, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign bus_req   = st_q.busy;
    assign bus_we    = st_q.we;
    assign bus_waddr = st_q.waddr;
    assign bus_be    = st_q.be;
    assign bus_wdata = st_q.wdata;
    assign ld_valid  = st_q.ld_vld;
    assign ld_idx    = st_q.idx;
    assign ld_data   = st_q.ld_data;
    assign mis_flag  = st_q.mis;

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned WA_W  = DATA_W - $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             bus_req,
    input logic             bus_we,
    input logic [WA_W-1:0]  bus_waddr,
    input logic [LANES-1:0] bus_be,
    input logic             bus_ack,
    input logic             ld_valid,
    input logic             mis_flag
);
    localparam logic [LANES-1:0] HALF_HI = {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
    localparam logic [LANES-1:0] HALF_LO = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_waddr) && $stable(bus_be)); // R8

    AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(req_valid)); // R2

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == 1) || (bus_be == HALF_HI)
                 || (bus_be == HALF_LO) || (bus_be == '1)); // R3

    AST_MIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mis_flag |-> !bus_req); // R5

    AST_MIS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mis_flag |=> !mis_flag); // R5

    AST_LDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid); // R7

    AST_LDV_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(bus_req && bus_ack && !bus_we)); // R7

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_be    (bus_be),
    .bus_ack   (bus_ack),
    .ld_valid  (ld_valid),
    .mis_flag  (mis_flag)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  base_sel, src_sel;
    logic [31:0] base_val = '0;
    logic [31:0] src_val = '0;
    logic        busy, bus_req, bus_we;
    logic [29:0] bus_waddr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        ld_valid;
    logic [4:0]  ld_idx;
    logic [31:0] ld_data;
    logic        mis_flag;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    lsu_lane_align u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
        .base_sel(base_sel), .src_sel(src_sel), .base_val(base_val), .src_val(src_val),
        .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data), .mis_flag(mis_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] ridx,
                                       input logic [15:0] imm);
        return {op, 5'd3, ridx, imm};
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] rs, input logic [31:0] rt);
        @(negedge clk);
        instr = ins; base_val = rs; src_val = rt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_store(input logic [5:0] op, input logic [31:0] rs, input logic [15:0] imm,
                             input logic [31:0] rt, input logic [29:0] ewa,
                             input logic [3:0] ebe, input logic [31:0] ewd);
        issue(mk(op, 5'd9, imm), rs, rt);
        chk("R8 store request raised", 32'(bus_req), 32'd1);
        chk("R4 store write strobe", 32'(bus_we), 32'd1);
        chk("R1 store word address", 32'(bus_waddr), 32'(ewa));
        chk("R3 store byte enables", 32'(bus_be), 32'(ebe));
        chk("R4 store lane data", bus_wdata, ewd);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk("R8 store request dropped after ack", 32'(bus_req), 32'd0);
        chk("R7 no load pulse on store", 32'(ld_valid), 32'd0);
    endtask

    task automatic run_load(input logic [5:0] op, input logic [4:0] ridx, input logic [31:0] rs,
                            input logic [15:0] imm, input logic [31:0] rd, input int dly,
                            input logic [29:0] ewa, input logic [3:0] ebe,
                            input logic [31:0] edata);
        issue(mk(op, ridx, imm), rs, 32'h5555_5555);
        chk("R8 load request raised", 32'(bus_req), 32'd1);
        chk("R2 load is a read", 32'(bus_we), 32'd0);
        chk("R1 load word address", 32'(bus_waddr), 32'(ewa));
        chk("R3 load byte enables", 32'(bus_be), 32'(ebe));
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R8 request held while waiting", 32'(bus_req), 32'd1);
        end
        bus_ack = 1'b1; bus_rdata = rd;
        @(negedge clk);
        bus_ack = 1'b0; bus_rdata = 32'hxxxx_xxxx;
        chk("R7 load pulse", 32'(ld_valid), 32'd1);
        chk("R7 load destination index", 32'(ld_idx), 32'(ridx));
        chk("R6 load extracted data", ld_data, edata);
        @(negedge clk);
        chk("R7 load pulse is one cycle", 32'(ld_valid), 32'd0);
    endtask

    task automatic run_misalign(input logic [5:0] op, input logic [31:0] rs, input logic [15:0] imm);
        issue(mk(op, 5'd4, imm), rs, 32'h0);
        chk("R5 misalign flag raised", 32'(mis_flag), 32'd1);
        chk("R5 no bus request on misalign", 32'(bus_req), 32'd0);
        @(negedge clk);
        chk("R5 misalign flag is one cycle", 32'(mis_flag), 32'd0);
        chk("R5 still no bus request", 32'(bus_req), 32'd0);
    endtask

    task automatic run_other_opcode();
        issue(mk(6'd45, 5'd2, 16'h0000), 32'h1000, 32'h0);
        chk("R2 foreign opcode gives no request", 32'(bus_req), 32'd0);
        chk("R2 foreign opcode gives no flag", 32'(mis_flag), 32'd0);
        chk("R2 foreign opcode leaves idle", 32'(busy), 32'd0);
    endtask

    task automatic run_busy_ignore();
        // load at 0x5000, then a store presented while it waits
        issue(mk(6'd10, 5'd12, 16'h0000), 32'h5000, 32'h0);
        chk("R8 first request raised", 32'(bus_req), 32'd1);
        instr = mk(6'd22, 5'd1, 16'h0000); base_val = 32'h9000; src_val = 32'h1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 address held while busy", 32'(bus_waddr), 32'h1400);
        chk("R8 direction held while busy", 32'(bus_we), 32'd0);
        bus_ack = 1'b1; bus_rdata = 32'h0BAD_F00D;
        @(negedge clk);
        bus_ack = 1'b0;
        chk("R7 first load completes", ld_data, 32'h0BAD_F00D);
        chk("R8 ignored request starts nothing", 32'(bus_req), 32'd0);
        @(negedge clk);
        chk("R8 still idle afterwards", 32'(bus_req), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset busy", 32'(busy), 32'd0);
        chk("R9 reset bus_req", 32'(bus_req), 32'd0);
        chk("R9 reset ld_valid", 32'(ld_valid), 32'd0);
        chk("R9 reset mis_flag", 32'(mis_flag), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // stores (R1, R3, R4)
        run_store(6'd12, 32'h1000, 16'h0003, 32'h1234_56AB, 30'h400, 4'b0001, 32'hABAB_ABAB);
        run_store(6'd12, 32'h1001, 16'hFFFF, 32'h0000_00C3, 30'h400, 4'b1000, 32'hC3C3_C3C3);
        run_store(6'd3,  32'h2000, 16'h0002, 32'hDEAD_BEEF, 30'h800, 4'b0011, 32'hBEEF_BEEF);
        run_store(6'd3,  32'h2000, 16'h0000, 32'h0000_7A5C, 30'h800, 4'b1100, 32'h7A5C_7A5C);
        run_store(6'd22, 32'h0100, 16'hFFFC, 32'hCAFE_F00D, 30'h03F, 4'b1111, 32'hCAFE_F00D);

        // loads (R6, R7)
        run_load(6'd4,  5'd7,  32'h3000, 16'h0001, 32'h11F2_3344, 0, 30'hC00, 4'b0100, 32'hFFFF_FFF2);
        run_load(6'd16, 5'd8,  32'h3000, 16'h0001, 32'h11F2_3344, 1, 30'hC00, 4'b0100, 32'h0000_00F2);
        run_load(6'd4,  5'd31, 32'h3000, 16'h0003, 32'hFFFF_FF7F, 0, 30'hC00, 4'b0001, 32'h0000_007F);
        run_load(6'd16, 5'd1,  32'h3000, 16'h0000, 32'h9A00_0000, 0, 30'hC00, 4'b1000, 32'h0000_009A);
        run_load(6'd7,  5'd2,  32'h3000, 16'h0002, 32'h1234_8001, 2, 30'hC00, 4'b0011, 32'hFFFF_8001);
        run_load(6'd11, 5'd3,  32'h3000, 16'h0000, 32'h8001_1234, 0, 30'hC00, 4'b1100, 32'h0000_8001);
        run_load(6'd7,  5'd5,  32'h3000, 16'h0000, 32'h7FFE_FFFF, 0, 30'hC00, 4'b1100, 32'h0000_7FFE);
        run_load(6'd10, 5'd6,  32'h4000, 16'h0008, 32'h89AB_CDEF, 3, 30'h1002, 4'b1111, 32'h89AB_CDEF);

        // misaligned (R5)
        run_misalign(6'd7,  32'h3000, 16'h0001);
        run_misalign(6'd10, 32'h3000, 16'h0002);
        run_misalign(6'd3,  32'h3000, 16'h0003);
        run_misalign(6'd22, 32'h3001, 16'h0000);

        // ignored input (R2, R8)
        run_other_opcode();
        run_busy_ignore();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule